// File: doc/BRIEF.md
# Locked Register-Memory Exchange Sequencer

This block swaps two operands. One operand is always an entry of a small register file. The other is either a second register entry or a word in memory. A one-cycle start pulse launches the swap. The caller supplies an operand-kind flag, an operand size, the register indices, a memory address and a segment-writability flag. The block latches these values, then runs a fixed sequence: it copies the destination into a temporary, writes the source into the destination, and writes the temporary back into the source.

In the memory form, the memory word is the destination and the register selected by the source index is the source. The block drives a synchronous memory port with byte enables. It holds a bus-lock output from the read through the write, whether or not a lock prefix is present and whatever the privilege level. If the segment is not writable, the block ends at once with a general-protection fault with code 0. In that case it touches no operand.

The register file also has a plain write port and a read port, so the surrounding pipeline can load operands and observe them. The swap has no status flags and changes none.

Top module: `xchg_seq`

## Requirements
- R1: With `mem_op_i`=0, a swap exchanges the low 8, 16 or 32 bits (`size_i` = 0, 1, 2) of registers `dst_idx_i` and `src_idx_i`. The upper bits of each register are kept. `done_o` pulses in the third cycle after the start edge.
- R2: With `mem_op_i`=1, the memory word at `addr_i` takes the low lanes of register `src_idx_i`, and that register takes the low bits of the old memory word. `done_o` pulses in the fifth cycle after the start edge.
- R3: In a memory swap, `bus_lock_o` is high in cycles 2 to 4 (the read, the capture and the write). It is low in cycle 1 and in the `done_o` cycle.
- R4: `bus_lock_o` is never high during a register swap. `lock_prefix_i` and `iopl_i` change neither the lock, the timing nor the results.
- R5: A memory swap with `seg_wr_ok_i`=0 raises `done_o` and `fault_o` in the first cycle after the start edge, with `fault_code_o`=0. It makes no memory access, raises no lock and changes no register.
- R6: Memory writes use `mem_be_o` = 0001 for a byte, 0011 for a word and 1111 for a dword, so a byte swap changes only byte lane 0 of the memory word. The read and the write both go to `addr_i`.
- R7: A start pulse that arrives while `busy_o` is high is ignored. It launches no later swap and touches none of the operands it names.
- R8: After reset, all registers read 0 and `busy_o`, `done_o`, `fault_o`, `bus_lock_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| mem_op_i | input | 1 | 0: register-register swap, 1: register-memory swap |
| size_i | input | 2 | Operand size: 0 byte, 1 word, 2 dword |
| dst_idx_i | input | 3 | Destination register (register form) |
| src_idx_i | input | 3 | Source register (both forms) |
| addr_i | input | 8 | Memory word address |
| seg_wr_ok_i | input | 1 | Memory segment is writable |
| lock_prefix_i | input | 1 | Lock prefix present (no effect) |
| iopl_i | input | 2 | I/O privilege level (no effect) |
| rf_we_i | input | 1 | External register write enable |
| rf_widx_i | input | 3 | External write index |
| rf_wdata_i | input | 32 | External write data |
| rf_ridx_i | input | 3 | Read port index |
| rf_rdata_o | output | 32 | Read port data |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory write (else read) |
| mem_addr_o | output | 8 | Memory address |
| mem_be_o | output | 4 | Memory byte enables |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, one cycle after a read |
| bus_lock_o | output | 1 | Bus lock |
| busy_o | output | 1 | Swap in progress |
| done_o | output | 1 | Swap finished (one-cycle pulse) |
| fault_o | output | 1 | General-protection fault |
| fault_code_o | output | 16 | Fault error code |

## Verification
A sequencer stuck in or skipping a state shows up at once as `done_o` arriving off its third or fifth cycle. It also shows up as a `bus_lock_o` window that no longer covers exactly cycles 2 to 4. A wrong temporary or a wrong write select only appears when the operands are read back after `done_o`. Mixed upper and lower bit patterns per size expose merge and lane errors there. A missed fault check shows within one cycle as a memory request, or later as a changed register.

// File: rtl/xchg_pkg.sv
package xchg_pkg;
  localparam logic [1:0] SZ_8  = 2'd0;
  localparam logic [1:0] SZ_16 = 2'd1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_R_TMP,
    ST_R_DST,
    ST_R_SRC,
    ST_M_CHK,
    ST_M_RD,
    ST_M_CAP,
    ST_M_WR,
    ST_M_WB
  } xchg_state_e;
endpackage

// File: rtl/xchg_regfile.sv
module xchg_regfile #(
  parameter int NREGS = 8,
  parameter int DW    = 32,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ra_idx_i,
  output logic [DW-1:0] ra_data_o,
  input  logic [IW-1:0] rb_idx_i,
  output logic [DW-1:0] rb_data_o,
  input  logic [IW-1:0] rc_idx_i,
  output logic [DW-1:0] rc_data_o
);
  logic [DW-1:0] regs_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            regs_q[g] <= '0;
      else if (we_i && widx_i == IW'(g))      regs_q[g] <= wdata_i;
    end
  end

  assign ra_data_o = regs_q[ra_idx_i];
  assign rb_data_o = regs_q[rb_idx_i];
  assign rc_data_o = regs_q[rc_idx_i];
endmodule

// File: rtl/xchg_lane.sv
module xchg_lane #(
  parameter int DW = 32,
  localparam int NB = DW / 8
) (
  input  logic [1:0]    size_i,
  output logic [DW-1:0] mask_o,
  output logic [NB-1:0] be_o
);
  import xchg_pkg::*;
  int unsigned nbytes;

  always_comb begin
    if (size_i == SZ_8)       nbytes = 1;
    else if (size_i == SZ_16) nbytes = (NB > 2) ? 2 : NB;
    else                      nbytes = NB;
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign be_o[b]          = (b < nbytes);
    assign mask_o[b*8 +: 8] = {8{be_o[b]}};
  end
endmodule

// File: rtl/xchg_ctrl.sv
module xchg_ctrl #(
  parameter int NREGS = 8,
  parameter int AW    = 8,
  localparam int IW   = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          mem_op_i,
  input  logic [1:0]    size_i,
  input  logic [IW-1:0] dst_idx_i,
  input  logic [IW-1:0] src_idx_i,
  input  logic [AW-1:0] addr_i,
  input  logic          seg_wr_ok_i,
  output logic [1:0]    size_q_o,
  output logic [IW-1:0] dst_q_o,
  output logic [IW-1:0] src_q_o,
  output logic [AW-1:0] addr_q_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          fault_o,
  output logic          lock_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic          tmp_ld_reg_o,
  output logic          tmp_ld_mem_o,
  output logic          rf_wr_o,
  output logic          rf_wr_dst_o
);
  import xchg_pkg::*;
  xchg_state_e state_q, state_d;
  logic seg_ok_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = mem_op_i ? ST_M_CHK : ST_R_TMP;
      ST_R_TMP: state_d = ST_R_DST;
      ST_R_DST: state_d = ST_R_SRC;
      ST_R_SRC: state_d = ST_IDLE;
      ST_M_CHK: state_d = seg_ok_q ? ST_M_RD : ST_IDLE;
      ST_M_RD:  state_d = ST_M_CAP;
      ST_M_CAP: state_d = ST_M_WR;
      ST_M_WR:  state_d = ST_M_WB;
      ST_M_WB:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      seg_ok_q <= 1'b0;
      size_q_o <= '0;
      dst_q_o  <= '0;
      src_q_o  <= '0;
      addr_q_o <= '0;
    end else begin
      state_q <= state_d;
      // operands latched only on an accepted start
      if (state_q == ST_IDLE && start_i) begin
        seg_ok_q <= seg_wr_ok_i;
        size_q_o <= size_i;
        dst_q_o  <= dst_idx_i;
        src_q_o  <= src_idx_i;
        addr_q_o <= addr_i;
      end
    end
  end

  always_comb begin
    busy_o       = (state_q != ST_IDLE);
    fault_o      = (state_q == ST_M_CHK) && !seg_ok_q;
    done_o       = (state_q == ST_R_SRC) || (state_q == ST_M_WB) || fault_o;
    lock_o       = (state_q == ST_M_RD) || (state_q == ST_M_CAP) || (state_q == ST_M_WR);
    mem_req_o    = (state_q == ST_M_RD) || (state_q == ST_M_WR);
    mem_we_o     = (state_q == ST_M_WR);
    tmp_ld_reg_o = (state_q == ST_R_TMP);
    tmp_ld_mem_o = (state_q == ST_M_CAP);
    rf_wr_o      = (state_q == ST_R_DST) || (state_q == ST_R_SRC) || (state_q == ST_M_WB);
    rf_wr_dst_o  = (state_q == ST_R_DST);
  end
endmodule

// File: rtl/xchg_seq.sv
module xchg_seq #(
  parameter int NREGS = 8,
  parameter int DW    = 32,
  parameter int AW    = 8,
  parameter int FCW   = 16,
  localparam int IW   = $clog2(NREGS),
  localparam int NB   = DW / 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           mem_op_i,
  input  logic [1:0]     size_i,
  input  logic [IW-1:0]  dst_idx_i,
  input  logic [IW-1:0]  src_idx_i,
  input  logic [AW-1:0]  addr_i,
  input  logic           seg_wr_ok_i,
  input  logic           lock_prefix_i,
  input  logic [1:0]     iopl_i,
  input  logic           rf_we_i,
  input  logic [IW-1:0]  rf_widx_i,
  input  logic [DW-1:0]  rf_wdata_i,
  input  logic [IW-1:0]  rf_ridx_i,
  output logic [DW-1:0]  rf_rdata_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [AW-1:0]  mem_addr_o,
  output logic [NB-1:0]  mem_be_o,
  output logic [DW-1:0]  mem_wdata_o,
  input  logic [DW-1:0]  mem_rdata_i,
  output logic           bus_lock_o,
  output logic           busy_o,
  output logic           done_o,
  output logic           fault_o,
  output logic [FCW-1:0] fault_code_o
);
  // lock is forced by the memory form alone; prefix and privilege are don't-cares
  logic unused_lock_ctl;
  assign unused_lock_ctl = ^{lock_prefix_i, iopl_i};

  logic [1:0]    size_q;
  logic [IW-1:0] dst_q, src_q;
  logic [AW-1:0] addr_q;
  logic          tmp_ld_reg, tmp_ld_mem, rf_wr, rf_wr_dst;
  logic [DW-1:0] dst_val, src_val, mask, tmp_q;
  logic          wr_en;
  logic [IW-1:0] wr_idx;
  logic [DW-1:0] wr_data, wr_old, wr_new;

  xchg_ctrl #(.NREGS(NREGS), .AW(AW)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .mem_op_i, .size_i, .dst_idx_i, .src_idx_i,
    .addr_i, .seg_wr_ok_i,
    .size_q_o(size_q), .dst_q_o(dst_q), .src_q_o(src_q), .addr_q_o(addr_q),
    .busy_o, .done_o, .fault_o, .lock_o(bus_lock_o), .mem_req_o, .mem_we_o,
    .tmp_ld_reg_o(tmp_ld_reg), .tmp_ld_mem_o(tmp_ld_mem),
    .rf_wr_o(rf_wr), .rf_wr_dst_o(rf_wr_dst)
  );

  xchg_lane #(.DW(DW)) u_lane (
    .size_i(size_q), .mask_o(mask), .be_o(mem_be_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         tmp_q <= '0;
    else if (tmp_ld_reg) tmp_q <= dst_val;
    else if (tmp_ld_mem) tmp_q <= mem_rdata_i;
  end

  always_comb begin
    wr_old  = rf_wr_dst ? dst_val : src_val;
    wr_new  = rf_wr_dst ? src_val : tmp_q;
    wr_en   = rf_wr || (rf_we_i && !busy_o);
    wr_idx  = rf_wr ? (rf_wr_dst ? dst_q : src_q) : rf_widx_i;
    wr_data = rf_wr ? ((wr_old & ~mask) | (wr_new & mask)) : rf_wdata_i;
  end

  xchg_regfile #(.NREGS(NREGS), .DW(DW)) u_rf (
    .clk_i, .rst_ni,
    .we_i(wr_en), .widx_i(wr_idx), .wdata_i(wr_data),
    .ra_idx_i(dst_q), .ra_data_o(dst_val),
    .rb_idx_i(src_q), .rb_data_o(src_val),
    .rc_idx_i(rf_ridx_i), .rc_data_o(rf_rdata_o)
  );

  assign mem_addr_o   = addr_q;
  assign mem_wdata_o  = src_val;
  assign fault_code_o = '0;
endmodule

// File: rtl/xchg_seq_chk.sv
module xchg_seq_chk #(
  parameter int NB  = 4,
  parameter int FCW = 16
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           mem_op_i,
  input logic [1:0]     size_q,
  input logic           mem_req_o,
  input logic           mem_we_o,
  input logic [NB-1:0]  mem_be_o,
  input logic           bus_lock_o,
  input logic           busy_o,
  input logic           done_o,
  input logic           fault_o,
  input logic [FCW-1:0] fault_code_o
);
  AST_LOCK_OFF_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !bus_lock_o);  // R3
  AST_LOCK_STARTS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_lock_o) |-> mem_req_o && !mem_we_o);  // R3
  AST_LOCK_ENDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_lock_o) |-> done_o);  // R3
  AST_MEM_UNDER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> bus_lock_o && busy_o);  // R4
  AST_WRITE_AFTER_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> $past(bus_lock_o));  // R2
  AST_FAULT_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o && !bus_lock_o && !mem_req_o && fault_code_o == '0);  // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R1
  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);  // R7
  AST_BYTE_LANE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && size_q == 2'd0) |-> mem_be_o == NB'(1));  // R6
  AST_BE_CONTIG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_be_o[0] && $onehot0(mem_be_o + NB'(1)));  // R6
  AST_LOCK_IDLE_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o) |-> !bus_lock_o);  // R4
  wire unused_chk = mem_op_i;
endmodule

bind xchg_seq xchg_seq_chk #(.NB(NB), .FCW(FCW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_op_i(mem_op_i), .size_q(size_q),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_be_o(mem_be_o),
  .bus_lock_o(bus_lock_o), .busy_o(busy_o), .done_o(done_o),
  .fault_o(fault_o), .fault_code_o(fault_code_o)
);

// File: tb/xchg_seq_tb.sv
module xchg_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, mem_op_i = 1'b0, seg_wr_ok_i = 1'b1;
  logic [1:0]  size_i = '0, iopl_i = '0;
  logic [2:0]  dst_idx_i = '0, src_idx_i = '0, rf_widx_i = '0, rf_ridx_i = '0;
  logic [7:0]  addr_i = '0;
  logic        lock_prefix_i = 1'b0, rf_we_i = 1'b0;
  logic [31:0] rf_wdata_i = '0, rf_rdata_o, mem_wdata_o, mem_rdata_i;
  logic        mem_req_o, mem_we_o, bus_lock_o, busy_o, done_o, fault_o;
  logic [7:0]  mem_addr_o;
  logic [3:0]  mem_be_o;
  logic [15:0] fault_code_o;

  int checks = 0, failures = 0, mem_acc = 0;
  logic [31:0] bmem [16];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  xchg_seq u_dut (.*);

  always @(posedge clk_i) begin
    if (mem_req_o) begin
      mem_acc <= mem_acc + 1;
      if (mem_we_o) begin
        for (int b = 0; b < 4; b++)
          if (mem_be_o[b]) bmem[mem_addr_o[3:0]][b*8 +: 8] <= mem_wdata_o[b*8 +: 8];
      end else mem_rdata_i <= bmem[mem_addr_o[3:0]];
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk_i);
    rf_we_i = 1'b1; rf_widx_i = idx; rf_wdata_i = val;
    @(negedge clk_i);
    rf_we_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] idx, output logic [31:0] val);
    @(negedge clk_i);
    rf_ridx_i = idx;
    #1 val = rf_rdata_o;
  endtask

  task automatic run(input logic mem, input logic [1:0] sz, input logic [2:0] d,
                     input logic [2:0] s, input logic [7:0] ad, input logic pf,
                     input logic seg, output int ncyc, output logic [7:0] lk,
                     output logic flt);
    @(negedge clk_i);
    mem_op_i = mem; size_i = sz; dst_idx_i = d; src_idx_i = s; addr_i = ad;
    lock_prefix_i = pf; iopl_i = {pf, pf}; seg_wr_ok_i = seg; start_i = 1'b1;
    ncyc = 0; lk = '0; flt = 1'b0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      lk[k[2:0]] = bus_lock_o;
      if (done_o) begin ncyc = k; flt = fault_o; break; end
    end
  endtask

  typedef struct packed {
    logic        mem;
    logic [1:0]  size;
    logic        pref;
    logic [2:0]  a;
    logic [2:0]  b;
    logic [7:0]  addr;
    logic [31:0] va;
    logic [31:0] vb;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 2'd2, 1'b0, 3'd1, 3'd2, 8'd0,  32'h11112222, 32'hAAAA5555},
    '{1'b0, 2'd1, 1'b1, 3'd3, 3'd4, 8'd0,  32'hDEADBEEF, 32'h01234567},
    '{1'b0, 2'd0, 1'b1, 3'd0, 3'd7, 8'd0,  32'hCAFEF00D, 32'h12345678},
    '{1'b1, 2'd2, 1'b0, 3'd0, 3'd5, 8'd3,  32'h0F0F0F0F, 32'hF00DFACE},
    '{1'b1, 2'd1, 1'b1, 3'd0, 3'd6, 8'd9,  32'h89ABCDEF, 32'h76543210},
    '{1'b1, 2'd0, 1'b0, 3'd0, 3'd2, 8'd15, 32'hA5A5A5A5, 32'h3C3C3C3C}
  };

  function automatic logic [31:0] sz_mask(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'h0000_00FF : (sz == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int n; logic [7:0] lk; logic f; logic [31:0] v, m;
    for (int i = 0; i < 16; i++) bmem[i] = 32'h0;
    mem_rdata_i = '0;
    repeat (3) @(negedge clk_i);
    // R8 reset state
    rf_ridx_i = 3'd5; #1;
    chk("R8 reg", rf_rdata_o, 32'h0);
    chk("R8 ctl", {28'h0, busy_o, done_o, fault_o, bus_lock_o}, 32'h0);
    chk("R8 mreq", {31'h0, mem_req_o}, 32'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < 6; i++) begin
      m = sz_mask(VEC[i].size);
      if (VEC[i].mem) begin
        wr_reg(VEC[i].b, VEC[i].va);
        bmem[VEC[i].addr[3:0]] = VEC[i].vb;
        run(1'b1, VEC[i].size, 3'd0, VEC[i].b, VEC[i].addr, VEC[i].pref, 1'b1, n, lk, f);
        chk("R2 cycles", n, 5);
        chk("R3 lock window", {24'h0, lk}, 32'h1C);
        chk("R5 no fault", {31'h0, f}, 32'h0);
        rd_reg(VEC[i].b, v);
        chk("R2 reg", v, (VEC[i].va & ~m) | (VEC[i].vb & m));
        chk("R6 mem lanes", bmem[VEC[i].addr[3:0]], (VEC[i].vb & ~m) | (VEC[i].va & m));
      end else begin
        wr_reg(VEC[i].a, VEC[i].va);
        wr_reg(VEC[i].b, VEC[i].vb);
        run(1'b0, VEC[i].size, VEC[i].a, VEC[i].b, 8'd0, VEC[i].pref, 1'b1, n, lk, f);
        chk("R1 cycles", n, 3);
        chk("R4 no lock", {24'h0, lk}, 32'h0);
        chk("R5 no fault", {31'h0, f}, 32'h0);
        rd_reg(VEC[i].a, v);
        chk("R1 dst", v, (VEC[i].va & ~m) | (VEC[i].vb & m));
        rd_reg(VEC[i].b, v);
        chk("R1 src", v, (VEC[i].vb & ~m) | (VEC[i].va & m));
      end
    end

    // R5 non-writable segment
    wr_reg(3'd4, 32'h5A5A1234);
    bmem[7] = 32'h00C0FFEE;
    mem_acc = 0;
    run(1'b1, 2'd2, 3'd0, 3'd4, 8'd7, 1'b1, 1'b0, n, lk, f);
    chk("R5 fault cycle", n, 1);
    chk("R5 fault", {31'h0, f}, 32'h1);
    chk("R5 code", {16'h0, fault_code_o}, 32'h0);
    chk("R5 no lock", {24'h0, lk}, 32'h0);
    repeat (2) @(negedge clk_i);
    chk("R5 no access", mem_acc, 0);
    chk("R5 mem kept", bmem[7], 32'h00C0FFEE);
    rd_reg(3'd4, v);
    chk("R5 reg kept", v, 32'h5A5A1234);

    // R7 start while busy is ignored
    wr_reg(3'd1, 32'h0000_0001);
    wr_reg(3'd2, 32'h0000_0002);
    wr_reg(3'd6, 32'h6666_6666);
    bmem[11] = 32'hBBBB_BBBB;
    mem_acc = 0;
    @(negedge clk_i);
    mem_op_i = 1'b0; size_i = 2'd2; dst_idx_i = 3'd1; src_idx_i = 3'd2; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b1; mem_op_i = 1'b1; src_idx_i = 3'd6; addr_i = 8'd11; seg_wr_ok_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    chk("R7 first done", {31'h0, done_o}, 32'h1);
    n = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk_i);
      if (busy_o || done_o) n++;
    end
    chk("R7 no relaunch", n, 0);
    chk("R7 no access", mem_acc, 0);
    chk("R7 mem kept", bmem[11], 32'hBBBB_BBBB);
    rd_reg(3'd6, v);
    chk("R7 reg kept", v, 32'h6666_6666);
    rd_reg(3'd1, v);
    chk("R1 busy swap dst", v, 32'h0000_0002);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule